// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a wide synchronous up-counter assembled from a parameterised number of 4-bit binary stages. Every stage sees the same clock, the same clear, the same load strobe and the same count-enable. Each stage passes a terminal-count signal to the next stage, where it acts as that stage's carry enable. The chain therefore behaves as one binary value of `N_STG*4` bits. A stage advances only when every nibble below it is all ones and the carry input is high.

The clear and the load are both synchronous. Clear has priority over load, load has priority over counting, and counting needs both the shared enable and the carry to be high. The chain terminal count is combinational. It rises while the carry input is high and the whole value is all ones, so a second counter block can be chained after this one.

Setting the parameter `MOD` to a nonzero value adds a decoder on the counter value. When the value equals `MOD-1`, the decoder raises an internal synchronous clear. The value `MOD-1` is held for one clock and the count then returns to zero. The chain then counts modulo `MOD`.

Top module: `cascade_counter`

## Requirements
- R1: When `clear_i` is high at a rising edge, `count_o` becomes 0 after that edge, whatever the values of `load_i`, `cnt_en_i` and `carry_in_i`.
- R2: When `load_i` is high and `clear_i` is low at a rising edge, `count_o` takes `load_val_i` after that edge, whatever the values of both enables.
- R3: When `clear_i` and `load_i` are low and both `cnt_en_i` and `carry_in_i` are high, `count_o` increases by exactly one at the edge.
- R4: When `clear_i` and `load_i` are low and either enable is low, `count_o` keeps its value across the edge.
- R5: `term_o` is high exactly when `carry_in_i` is high and `count_o` is all ones. It follows `carry_in_i` in the same cycle without waiting for a clock edge.
- R6: A counting edge with `count_o` all ones yields `count_o` = 0.
- R7: Nibble k (bits 4k+3 down to 4k) advances on a counting edge only when every lower nibble is 1111. For example, 0x0F advances to 0x10 and 0x3F advances to 0x40.
- R8: With `MOD` nonzero, a clock edge with `count_o` = `MOD-1` and `clear_i` low yields `count_o` = 0. This holds even when `load_i` is high or the enables are low. With `MOD` = 0 no truncation occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clear_i | input | 1 | Synchronous master clear, active high, highest priority |
| load_i | input | 1 | Synchronous parallel load strobe, active high |
| cnt_en_i | input | 1 | Count enable shared by all stages |
| carry_in_i | input | 1 | Carry enable of the lowest stage |
| load_val_i | input | N_STG*4 | Value loaded into the chain |
| count_o | output | N_STG*4 | Chained counter value |
| term_o | output | 1 | Chain terminal count, carry output of the top stage |

## Verification
Several controls can be active in the same cycle, and the priority between them is what is checked. Clear is raised together with load, load is raised together with both enables, and the truncation decode is reached while load is high or the enables are low. The expected result is always the one produced by the higher-priority action. These collisions are driven by a directed vector table, by directed sequences on a truncating instance, and by random control patterns. A reference counter that models the priority order judges every post-edge value and every pre-edge terminal count.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    // Per-stage operation, listed in increasing priority
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } stage_op_e;

    // Control bundle seen by one stage
    typedef struct packed {
        logic clear;
        logic load;
        logic en_par;
        logic en_car;
    } stage_ctl_t;

    function automatic stage_op_e pick_op(stage_ctl_t c);
        stage_op_e op;
        if (c.clear)                    op = OP_CLEAR;
        else if (c.load)                op = OP_LOAD;
        else if (c.en_par && c.en_car)  op = OP_COUNT;
        else                            op = OP_HOLD;
        return op;
    endfunction

    function automatic nib_t nib_next(stage_op_e op, nib_t q, nib_t d);
        nib_t n;
        unique case (op)
            OP_CLEAR: n = '0;
            OP_LOAD:  n = d;
            OP_COUNT: n = q + nib_t'(1);
            default:  n = q;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
(
    input  logic       clk,
    input  stage_ctl_t ctl,
    input  nib_t       d,
    output nib_t       q,
    output logic       tc
);

    stage_op_e op;
    nib_t      q_r;

    always_comb op = pick_op(ctl);

    always_ff @(posedge clk) begin
        q_r <= nib_next(op, q_r, d);
    end

    assign q  = q_r;
    assign tc = ctl.en_car & (&q_r);

    // R1 / R8: clear (external or truncation) zeroes the stage
    a_r1_clear_zero: assert property (@(posedge clk)
        ctl.clear |=> (q == '0));

    // R2: load takes the data
    a_r2_load_takes: assert property (@(posedge clk) disable iff (ctl.clear)
        ctl.load |=> (q == $past(d)));

    // R4: no enable pair means hold
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (ctl.clear)
        (!ctl.load && !(ctl.en_par && ctl.en_car)) |=> $stable(q));

    // R6: all ones wraps to zero
    a_r6_nib_wrap: assert property (@(posedge clk) disable iff (ctl.clear)
        (!ctl.load && ctl.en_par && ctl.en_car && (q == '1)) |=> (q == '0));

endmodule

// File: rtl/cnt_trunc.sv
module cnt_trunc
    import cnt_pkg::*;
#(
    parameter int N_STG = 2,
    parameter int MOD   = 0
) (
    input  logic [N_STG*NIB_W-1:0] value,
    output logic                   trunc_clr
);

    localparam int W = N_STG * NIB_W;

    generate
        if (MOD == 0) begin : g_free
            assign trunc_clr = 1'b0;
        end else begin : g_trunc
            localparam logic [W-1:0] LAST = W'(MOD - 1);
            assign trunc_clr = (value == LAST);
        end
    endgenerate

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int N_STG = 2,
    parameter int MOD   = 0
) (
    input  logic                   clk,
    input  logic                   clear_i,
    input  logic                   load_i,
    input  logic                   cnt_en_i,
    input  logic                   carry_in_i,
    input  logic [N_STG*NIB_W-1:0] load_val_i,
    output logic [N_STG*NIB_W-1:0] count_o,
    output logic                   term_o
);

    localparam int W = N_STG * NIB_W;

    logic [N_STG:0] carry;
    logic           trunc_clr;

    assign carry[0] = carry_in_i;

    cnt_trunc #(.N_STG(N_STG), .MOD(MOD)) trunc_i (
        .value     (count_o),
        .trunc_clr (trunc_clr)
    );

    generate
        for (genvar k = 0; k < N_STG; k++) begin : g_stg
            stage_ctl_t ctl;
            always_comb begin
                ctl.clear  = clear_i | trunc_clr;
                ctl.load   = load_i;
                ctl.en_par = cnt_en_i;
                ctl.en_car = carry[k];
            end
            cnt_stage stage_i (
                .clk (clk),
                .ctl (ctl),
                .d   (load_val_i[k*NIB_W +: NIB_W]),
                .q   (count_o[k*NIB_W +: NIB_W]),
                .tc  (carry[k+1])
            );
        end
    endgenerate

    assign term_o = carry[N_STG];

    // R3 / R7: whole chain adds exactly one per counting edge
    a_r3_chain_incr: assert property (@(posedge clk) disable iff (clear_i)
        (!trunc_clr && !load_i && cnt_en_i && carry_in_i)
        |=> (count_o == $past(count_o) + W'(1)));

    // R5: a low carry input forces the chain terminal count low
    always_comb begin
        a_r5_term_gated: assert (carry_in_i || !term_o);
    end

    // R6: chain wraps from all ones
    a_r6_chain_wrap: assert property (@(posedge clk) disable iff (clear_i)
        (!load_i && cnt_en_i && carry_in_i && (count_o == '1)) |=> (count_o == '0));

    generate
        if (MOD != 0) begin : g_mod_chk
            // R8: decoded last value returns to zero on the next edge
            a_r8_trunc_zero: assert property (@(posedge clk) disable iff (clear_i)
                (count_o == W'(MOD - 1)) |=> (count_o == '0));
        end
    endgenerate

endmodule

// File: tb/cascade_counter_tb_top.sv
`timescale 1ns/1ps
module cascade_counter_tb_top;

    localparam int N    = 2;
    localparam int W    = N * 4;
    localparam int MODV = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         clr = 1'b1, ld = 1'b0, en = 1'b0, car = 1'b0;
    logic [W-1:0] val = '0;
    logic [W-1:0] cnt_a, cnt_b;
    logic         term_a, term_b;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] ma = '0, mb = '0;
    bit done = 0;

    cascade_counter #(.N_STG(N), .MOD(0)) dut_i (
        .clk(clk), .clear_i(clr), .load_i(ld), .cnt_en_i(en), .carry_in_i(car),
        .load_val_i(val), .count_o(cnt_a), .term_o(term_a));

    cascade_counter #(.N_STG(N), .MOD(MODV)) dut_mod_i (
        .clk(clk), .clear_i(clr), .load_i(ld), .cnt_en_i(en), .carry_in_i(car),
        .load_val_i(val), .count_o(cnt_b), .term_o(term_b));

    // Stimulus {clear,load,en,carry}, load value, expected count after the edge
    localparam int NV = 15;
    localparam logic [19:0] TBL [NV] = '{
        20'hB_00_00, 20'h7_0C_0C, 20'h3_00_0D, 20'h3_00_0E, 20'h3_00_0F,
        20'h3_00_10, 20'h1_00_10, 20'h2_00_10, 20'h4_FE_FE, 20'h3_00_FF,
        20'h3_00_00, 20'hF_55_00, 20'h5_3F_3F, 20'h1_00_3F, 20'h3_00_40
    };

    function automatic logic [W-1:0] mdl(logic [W-1:0] q, logic c, logic l,
                                         logic e, logic y, logic [W-1:0] v, int md);
        if (c)                            return '0;
        if (md != 0 && q == W'(md - 1))   return '0;
        if (l)                            return v;
        if (e && y)                       return q + W'(1);
        return q;
    endfunction

    function automatic string lab(logic [W-1:0] q, logic c, logic l, logic e,
                                  logic y, int md);
        if (c)                            return "R1";
        if (md != 0 && q == W'(md - 1))   return "R8";
        if (l)                            return "R2";
        if (!(e && y))                    return "R4";
        if (q == '1)                      return "R6";
        if (q[3:0] == 4'hF)               return "R7";
        return "R3";
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive after a falling edge, check terminal counts before the rising edge,
    // check counts after it at the next falling edge.
    task automatic step(logic c, logic l, logic e, logic y, logic [W-1:0] v,
                        bit use_x, logic [W-1:0] x);
        string la, lb;
        clr = c; ld = l; en = e; car = y; val = v;
        #1;
        chk("R5", W'(term_a), W'(car && ma == '1));
        chk("R5", W'(term_b), W'(car && mb == '1));
        la = lab(ma, c, l, e, y, 0);
        lb = lab(mb, c, l, e, y, MODV);
        @(posedge clk);
        ma = mdl(ma, c, l, e, y, v, 0);
        mb = mdl(mb, c, l, e, y, v, MODV);
        @(negedge clk);
        if (use_x) chk(la, cnt_a, x);
        else       chk(la, cnt_a, ma);
        chk(lb, cnt_b, mb);
    endtask

    initial begin
        @(negedge clk);
        // reset state (R1)
        step(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1, '0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            step(TBL[i][19], TBL[i][18], TBL[i][17], TBL[i][16],
                 TBL[i][15:8], 1'b1, TBL[i][7:0]);
        end

        // R5: terminal count follows the carry input inside one cycle
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, '0);
        car = 1'b1; en = 1'b0; ld = 1'b0;
        #1 chk("R5", W'(term_a), W'(1));
        car = 1'b0;
        #1 chk("R5", W'(term_a), W'(0));
        @(posedge clk);
        @(negedge clk);
        chk("R4", cnt_a, ma);

        // R8: truncation at MOD-1, including with enables low and with load high
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'd7, 1'b0, '0);
        step(1'b0, 1'b0, 1'b1, 1'b1, '0, 1'b0, '0);
        chk("R8", cnt_b, 8'd8);
        step(1'b0, 1'b0, 1'b1, 1'b1, '0, 1'b0, '0);
        chk("R8", cnt_b, 8'd9);
        step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
        chk("R8", cnt_b, 8'd0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'd9, 1'b0, '0);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'd5, 1'b0, '0);
        chk("R8", cnt_b, 8'd0);
        chk("R2", cnt_a, 8'd5);

        // random control patterns against the reference counter
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] rv;
            logic rc, rl, re, ry;
            rc = (($urandom % 40) == 0);
            rl = (($urandom % 8) == 0);
            re = (($urandom % 4) != 0);
            ry = (($urandom % 4) != 0);
            rv = (($urandom % 4) == 0) ? 8'hFD + W'($urandom % 3) : W'($urandom % MODV);
            step(rc, rl, re, ry, rv, 1'b0, '0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule